// File: doc/BRIEF.md
# Pulse-Stamped Interval Timer

This block measures elapsed time for a host that wants to know exactly how long passed between two of its own timer interrupts. A free-running count advances once per cycle of a 100 MHz clock, so each count is 10 ns. The clock is assumed to be locked to a disciplined 10 MHz frequency source. The host reads a register at each interrupt. That read returns the time counted since the previous such read and, in the same clock edge, starts a fresh measurement. No cycle is lost or counted twice at the handover.

The block also watches a once-per-second pulse input. It synchronises the pulse into the clock domain and finds its rising edge. At that edge it stamps the running count into a holding register and bumps a small wrapping event tally. The tally travels in the top byte of the interval word, so software can tell that a second boundary fell inside the interval it just read.

Access is through a plain request/response read port: a strobe and a byte offset go in, and 32-bit data comes back one cycle later with a valid flag. Every strobe is accepted. The port applies no back-pressure: the response cannot be stalled and must be taken in the cycle it is valid.

Top module: `pps_interval_timer`

## Requirements
- R1: When no interval read is accepted, the active count rises by exactly one per clock and wraps from 2^CNT_W-1 to 0.
- R2: A read at offset 0x0 returns the active count in bits CNT_W-1:0, with all higher bits zero. It does not disturb counting.
- R3: A read at offset 0x4 returns the active count in bits CNT_W-1:0 and the event tally in bits 31:24. In the same edge it hands counting to the other counter, which reads 1 in the next cycle, so the switch cycle is counted once.
- R4: The pulse input passes through a two-flop synchroniser and a rising-edge detector. An edge sampled high at clock edge A, after a low sample at edge A-1, is acted on at edge A+2. At that edge the count value present before the edge is stored as the stamp.
- R5: A read at offset 0x8 returns the stored stamp in bits CNT_W-1:0, with all higher bits zero.
- R6: Each detected rising edge adds one to the 8-bit event tally, which wraps modulo 256. A pulse held high for many cycles counts once.
- R7: When a detected pulse edge and an offset 0x4 read act at the same edge, the stamp equals the interval value returned by that read. The tally returned by that read is the value before this edge's increment.
- R8: A read at any other offset returns zero and changes no count, stamp or tally.
- R9: Read data is registered. `rd_valid` is high exactly in the cycle after an accepted strobe, and low otherwise.
- R10: A synchronous active-high reset clears both counters, the stamp, the tally, the synchroniser and the read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous once-per-second pulse |
| rd_en | input | 1 | Read strobe, accepted every cycle |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | High in the cycle `rd_data` answers a strobe |

## Verification
The bench builds the block with CNT_W set to 10, so the count wraps after 1024 cycles. A directed quiet stretch of 1100 cycles therefore exercises the wrap of R1, which at the 24-bit default would take 2^24 cycles. The tally keeps its default 8 bits. The random pulse train produces several hundred edges, so the modulo-256 wrap of R6 is reached several times within the run. The synchroniser keeps its default two stages, so the two-cycle detection latency of R4 and the same-edge collision of R7 can be placed exactly by directed stimulus.

// File: rtl/pps_timer_pkg.sv
package pps_timer_pkg;
  // Byte offsets decoded by the read port
  localparam int OFF_NOW  = 'h0;  // live count, no side effect
  localparam int OFF_IVL  = 'h4;  // interval + tally, swaps counters
  localparam int OFF_STMP = 'h8;  // pulse stamp
endpackage

// File: rtl/pps_rise_detect.sv
module pps_rise_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_async,
  output logic rise_o
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its delayed copy
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], pulse_async};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/interval_pair.sv
module interval_pair #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             switch_i,
  output logic [CNT_W-1:0] act_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             sel;
  logic [CNT_W-1:0] cnt [2];

  always_ff @(posedge clk) begin
    if (rst)           sel <= 1'b0;
    else if (switch_i) sel <= ~sel;
  end

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    localparam logic ME = 1'(i);
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                   q <= '0;
      else if (sel == ME) begin
        if (!switch_i)           q <= q + ONE;  // frozen on handover
      end else if (switch_i)     q <= ONE;      // switch cycle counted here
    end
    assign cnt[i] = q;
  end

  assign act_o = sel ? cnt[1] : cnt[0];

  // R3
  handover_one_chk: assert property (@(posedge clk) disable iff (rst)
    switch_i |=> act_o == ONE);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !switch_i |=> act_o == $past(act_o) + ONE);
endmodule

// File: rtl/pps_stamp.sv
module pps_stamp #(
  parameter int CNT_W = 24,
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] stamp_o,
  output logic [EVT_W-1:0] evt_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_o <= '0;
      evt_o   <= '0;
    end else if (rise_i) begin
      stamp_o <= cnt_i;
      evt_o   <= evt_o + EVT_W'(1);
    end
  end
endmodule

// File: rtl/pps_interval_timer.sv
module pps_interval_timer
  import pps_timer_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int EVT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pps_in,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic             rise;
  logic             swap;
  logic             hit;
  logic [CNT_W-1:0] act_cnt;
  logic [CNT_W-1:0] stamp;
  logic [EVT_W-1:0] evt;
  logic [DATA_W-1:0] word;

  assign swap = rd_en && (rd_addr == ADDR_W'(OFF_IVL));

  pps_rise_detect #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pulse_async(pps_in), .rise_o(rise)
  );

  interval_pair #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .switch_i(swap), .act_o(act_cnt)
  );

  pps_stamp #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_stamp (
    .clk(clk), .rst(rst), .rise_i(rise), .cnt_i(act_cnt),
    .stamp_o(stamp), .evt_o(evt)
  );

  always_comb begin
    word = '0;
    hit  = 1'b1;
    case (rd_addr)
      ADDR_W'(OFF_NOW):  word[CNT_W-1:0] = act_cnt;
      ADDR_W'(OFF_IVL): begin
        word[CNT_W-1:0]           = act_cnt;
        word[DATA_W-1 -: EVT_W]   = evt;
      end
      ADDR_W'(OFF_STMP): word[CNT_W-1:0] = stamp;
      default:           hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word;
    end
  end

  // R9
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R8
  bad_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit) |=> rd_data == '0);
  // R7
  same_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && swap) |=> stamp == rd_data[CNT_W-1:0]);
endmodule

// File: tb/tb_pps_interval_timer.sv
module tb_pps_interval_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int EVT_W      = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pps_in = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  pps_interval_timer #(.CNT_W(CNT_W), .EVT_W(EVT_W)) dut (
    .clk(clk), .rst(rst), .pps_in(pps_in), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected-state model derived from the requirements
  logic [CNT_W-1:0] m_act;
  logic [EVT_W-1:0] m_evt;
  logic [CNT_W-1:0] m_stamp;
  logic             h1, h2, h3;
  logic             exp_v;
  logic [31:0]      exp_d;
  logic [31:0]      last_ivl;
  string            tag;

  function automatic logic [31:0] pack(logic [EVT_W-1:0] e, logic [CNT_W-1:0] c);
    logic [31:0] w;
    w = '0;
    w[CNT_W-1:0] = c;
    w[31 -: EVT_W] = e;
    return w;
  endfunction

  task automatic check(string t, logic [31:0] got, logic [31:0] expv);
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: got %h expected %h", t, got, expv);
    end
  endtask

  task automatic step(bit r, bit rd, logic [3:0] a, bit p);
    logic             rise;
    logic [CNT_W-1:0] nxt;
    rst = r; rd_en = rd; rd_addr = a; pps_in = p;
    rise = h2 & ~h3;
    if (r) begin
      exp_v = 1'b0; exp_d = '0; m_act = '0; m_evt = '0; m_stamp = '0;
      h1 = 1'b0; h2 = 1'b0; h3 = 1'b0; tag = "R10";
    end else begin
      exp_v = rd;
      if (rd) begin
        case (a)
          4'h0: begin exp_d = pack('0, m_act);    tag = "R1/R2"; end
          4'h4: begin exp_d = pack(m_evt, m_act); tag = "R3/R6"; last_ivl = exp_d; end
          4'h8: begin exp_d = pack('0, m_stamp);  tag = "R4/R5"; end
          default: begin exp_d = '0;              tag = "R8"; end
        endcase
      end
      nxt = (rd && a == 4'h4) ? CNT_W'(1) : m_act + CNT_W'(1);
      if (rise) begin
        m_stamp = m_act;
        m_evt   = m_evt + EVT_W'(1);
      end
      m_act = nxt;
      h3 = h2; h2 = h1; h1 = p;
    end
    @(posedge clk);
    @(negedge clk);
    check(r ? "R10 valid" : "R9 valid", {31'b0, rd_valid}, {31'b0, exp_v});
    if (exp_v || r) check(tag, rd_data, exp_d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int hold;
    bit p;
    void'($urandom(32'd914));
    @(negedge clk);
    repeat (4) step(1, 0, 4'h0, 0);                 // R10 reset state
    step(0, 1, 4'h0, 0);                             // R10 count starts at 0
    step(0, 1, 4'h8, 0);                             // R5 stamp cleared
    step(0, 1, 4'h4, 0);                             // R3 handover
    step(0, 1, 4'h0, 0);                             // R3 new counter reads 1
    repeat (1100) step(0, 0, 4'h0, 0);               // R1 wrap
    step(0, 1, 4'h0, 0);
    step(0, 1, 4'h4, 0);                             // R1 wrapped interval
    // R8 stray offsets, then confirm no switch happened
    step(0, 1, 4'hC, 0); step(0, 1, 4'h2, 0); step(0, 1, 4'hF, 0);
    step(0, 1, 4'h0, 0);
    // R7 pulse edge acts in the same edge as the interval read
    repeat (3) step(0, 0, 4'h0, 0);
    step(0, 0, 4'h0, 1); step(0, 0, 4'h0, 1);
    step(0, 1, 4'h4, 1);
    step(0, 1, 4'h8, 0);
    check("R7 stamp vs interval", {22'b0, rd_data[CNT_W-1:0]}, {22'b0, last_ivl[CNT_W-1:0]});
    // R6 long-held pulse counts once
    repeat (3) step(0, 0, 4'h0, 0);
    repeat (60) step(0, 0, 4'h0, 1);
    step(0, 1, 4'h4, 1);
    repeat (4) step(0, 0, 4'h0, 0);
    step(0, 1, 4'h4, 0);
    // random traffic mixed with a random pulse train
    hold = 4; p = 0;
    for (int n = 0; n < 8000; n++) begin
      int sel;
      logic [3:0] a;
      if (hold == 0) begin
        p = ~p;
        hold = int'($urandom_range(9, 2));
      end
      hold--;
      sel = int'($urandom % 8);
      case (sel)
        0, 1:    a = 4'h0;
        2:       a = 4'h4;
        3, 4:    a = 4'h8;
        default: a = 4'($urandom);
      endcase
      step(0, ($urandom % 3) == 0, a, p);
    end
    step(0, 1, 4'h4, 0);
    step(0, 1, 4'h8, 0);
    finish_run();
  end
endmodule